// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block holds the interrupt state of one processor: a 256-bit request register, a 256-bit in-service register, an 8-bit task priority and a processor priority derived from them. Sources raise a request by presenting a vector number for one cycle. The block shows the processor the highest pending vector. When the processor takes it, the vector moves from request to in-service. An end-of-interrupt strobe then retires the highest in-service vector.

Priority is decided on the class of a vector, which is its upper four bits. Nested in-service vectors sit on a small stack. The stack only grows in strictly rising class order, and its top, together with the task priority, sets the processor priority. Vectors 0 to 31 are reserved. They can be latched as requests, but they are never arbitrated and never retired. A word-wide register port lets software write the task priority and read the priorities and the 32-bit request and in-service words.

Top module: `irq_prio_arb`

## Requirements
- R1: After reset the request, in-service and task priority registers are zero, the stack is empty, pend_valid_o and eoi_err_o are low, and every register address reads zero.
- R2: A cycle with req_valid_i high sets the request bit of req_vec_i, for any vector 0..255. Vector n lives in 32-bit word n/32 at bit n mod 32. The request word w is read at address 8+w and the in-service word w at address 16+w.
- R3: Request bits of vectors 0..31 are never reported on pend_valid_o, never accepted and never touched by an end-of-interrupt.
- R4: pend_valid_o is high exactly when the highest set request bit among vectors 32..255 has a class (vector bits 7:4) strictly greater than the class of the processor priority. pend_vec_o then carries that vector, and is zero otherwise.
- R5: An accept (ack_i high while pend_valid_o is high and eoi_i is low) clears the request bit of pend_vec_o, sets its in-service bit and pushes it on the stack. Pushed classes rise strictly and the depth never exceeds STK_DEPTH.
- R6: eoi_i with a non-empty stack clears the highest set in-service bit among vectors 32..255 and pops the stack.
- R7: The processor priority (address 1) equals the task priority when the task priority's class is at least the class of the stack top. Otherwise it equals the stack top with bits 3:0 cleared. An empty stack counts as vector 0.
- R8: A write to address 0 stores bits 7:0 of reg_wdata_i as the task priority, and the processor priority and pending output follow from the next cycle on. Writes to any other address change nothing.
- R9: When a request and an accept of the same vector fall in one cycle, the request bit stays set and the in-service bit is set.
- R10: eoi_i with an empty stack changes no request, in-service or priority state and sets eoi_err_o, which stays high until reset.
- R11: ack_i is ignored when pend_valid_o is low or when eoi_i is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe for req_vec_i |
| req_vec_i | input | 8 | Vector being requested |
| pend_valid_o | output | 1 | A vector is ready for the processor |
| pend_vec_o | output | 8 | Highest pending vector, zero when none |
| ack_i | input | 1 | Processor takes pend_vec_o |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_err_o | output | 1 | Sticky flag: end-of-interrupt seen with nothing in service |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |

## Verification
The assertions assume that every accept is qualified inside the block. Under that assumption a push can only carry a class above the current stack top, so the stack can hold at most fourteen entries, one per class 2..15. They also assume that the stack and the in-service register change only together, so an end-of-interrupt always finds the stack top as the highest in-service bit. Because the block has a single request port, the stimulus can never raise more than one request per cycle. Every strobe is held for exactly one clock and driven between edges. Strobe combinations the block must resolve, such as a request with an accept or an accept with an end-of-interrupt, are produced deliberately.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int VEC_W     = 8;
  localparam int CLS_W     = 4;
  localparam int NUM_VEC   = 1 << VEC_W;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int WORD_AW   = $clog2(NUM_WORDS);
  localparam int REG_AW    = 2 + WORD_AW;
  localparam int RSVD_VEC  = 32;

  typedef enum logic [1:0] {
    SEL_CTL = 2'd0,
    SEL_REQ = 2'd1,
    SEL_SVC = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam logic [REG_AW-1:0] ADDR_TPR = '0;
  localparam logic [WORD_AW-1:0] WORD_PPR = WORD_AW'(1);
endpackage

// File: rtl/irq_hi_scan.sv
`timescale 1ns/1ps
module irq_hi_scan #(
  parameter int N  = 256,
  parameter int VW = 8,
  parameter int LO = 32
) (
  input  logic [N-1:0]  bits_i,
  output logic          found_o,
  output logic [VW-1:0] idx_o
);
  logic unused_low;
  assign unused_low = ^bits_i[LO-1:0];

  // ascending sweep: the last hit is the highest set bit at or above LO
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = LO; i < N; i++) begin
      if (bits_i[i]) begin
        found_o = 1'b1;
        idx_o   = VW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_svc_stack.sv
`timescale 1ns/1ps
module irq_svc_stack #(
  parameter int VW    = 8,
  parameter int DEPTH = 16,
  localparam int PW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [VW-1:0] push_vec_i,
  input  logic          pop_i,
  output logic [VW-1:0] top_o,
  output logic [PW-1:0] ptr_o,
  output logic          empty_o
);
  logic [PW-1:0] ptr_q;
  logic [VW-1:0] slot_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (push_i && ptr_q < PW'(DEPTH)) begin
      ptr_q <= ptr_q + 1'b1;
    end else if (pop_i && ptr_q != '0) begin
      ptr_q <= ptr_q - 1'b1;
    end
  end

  // slot i holds nesting level i+1; level 0 is the implicit vector 0
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[i] <= '0;
      end else if (push_i && ptr_q == PW'(i)) begin
        slot_q[i] <= push_vec_i;
      end
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ptr_q == PW'(i + 1)) top_o = slot_q[i];
    end
  end

  assign ptr_o   = ptr_q;
  assign empty_o = (ptr_q == '0);
endmodule

// File: rtl/irq_ppr_calc.sv
`timescale 1ns/1ps
module irq_ppr_calc #(
  parameter int VW = 8,
  parameter int CW = 4
) (
  input  logic [VW-1:0] tpr_i,
  input  logic [VW-1:0] top_i,
  output logic [VW-1:0] ppr_o
);
  logic [CW-1:0] tpr_cls, top_cls;
  logic unused_top_lo;

  assign tpr_cls       = tpr_i[VW-1 -: CW];
  assign top_cls       = top_i[VW-1 -: CW];
  assign unused_top_lo = ^top_i[VW-CW-1:0];
  assign ppr_o = (tpr_cls >= top_cls) ? tpr_i : {top_cls, {(VW-CW){1'b0}}};
endmodule

// File: rtl/irq_prio_arb.sv
`timescale 1ns/1ps
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int STK_DEPTH = 16,
  localparam int PTR_W    = $clog2(STK_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  output logic              pend_valid_o,
  output logic [VEC_W-1:0]  pend_vec_o,
  input  logic              ack_i,
  input  logic              eoi_i,
  output logic              eoi_err_o,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o
);
  localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);

  logic [NUM_VEC-1:0] irr_q, isr_q, irr_d, isr_d;
  logic [NUM_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr;
  logic [VEC_W-1:0]   tpr_q, ppr, stk_top, irr_hi, isr_hi;
  logic [PTR_W-1:0]   stk_ptr;
  logic               irr_hit, isr_hit, stk_empty;
  logic               accept, eoi_ok, eoi_bad, eoi_err_q;
  reg_sel_e           rd_sel;
  logic [WORD_AW-1:0] rd_word;
  logic               unused_wdata_hi;

  assign unused_wdata_hi = ^reg_wdata_i[WORD_W-1:VEC_W];

  irq_hi_scan #(.N(NUM_VEC), .VW(VEC_W), .LO(RSVD_VEC)) u_irr_scan (
    .bits_i (irr_q),
    .found_o(irr_hit),
    .idx_o  (irr_hi)
  );

  irq_hi_scan #(.N(NUM_VEC), .VW(VEC_W), .LO(RSVD_VEC)) u_isr_scan (
    .bits_i (isr_q),
    .found_o(isr_hit),
    .idx_o  (isr_hi)
  );

  irq_svc_stack #(.VW(VEC_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (accept),
    .push_vec_i(irr_hi),
    .pop_i     (eoi_ok),
    .top_o     (stk_top),
    .ptr_o     (stk_ptr),
    .empty_o   (stk_empty)
  );

  irq_ppr_calc #(.VW(VEC_W), .CW(CLS_W)) u_ppr (
    .tpr_i(tpr_q),
    .top_i(stk_top),
    .ppr_o(ppr)
  );

  assign pend_valid_o = irr_hit && (irr_hi[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]);
  assign pend_vec_o   = pend_valid_o ? irr_hi : '0;

  // an end-of-interrupt in the same cycle wins over an accept
  assign accept  = ack_i && pend_valid_o && !eoi_i;
  assign eoi_ok  = eoi_i && !stk_empty;
  assign eoi_bad = eoi_i && stk_empty;

  always_comb begin
    irr_clr = accept ? (ONE << irr_hi) : '0;
    irr_set = req_valid_i ? (ONE << req_vec_i) : '0;
    isr_set = accept ? (ONE << irr_hi) : '0;
    isr_clr = (eoi_ok && isr_hit) ? (ONE << isr_hi) : '0;
    irr_d   = (irr_q & ~irr_clr) | irr_set;
    isr_d   = (isr_q & ~isr_clr) | isr_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q     <= '0;
      isr_q     <= '0;
      tpr_q     <= '0;
      eoi_err_q <= 1'b0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      if (reg_we_i && reg_addr_i == ADDR_TPR) tpr_q <= reg_wdata_i[VEC_W-1:0];
      if (eoi_bad) eoi_err_q <= 1'b1;
    end
  end

  assign eoi_err_o = eoi_err_q;

  assign rd_sel  = reg_sel_e'(reg_addr_i[REG_AW-1 -: 2]);
  assign rd_word = reg_addr_i[WORD_AW-1:0];

  always_comb begin
    reg_rdata_o = '0;
    unique case (rd_sel)
      SEL_CTL: begin
        if (rd_word == '0)          reg_rdata_o = WORD_W'(tpr_q);
        else if (rd_word == WORD_PPR) reg_rdata_o = WORD_W'(ppr);
      end
      SEL_REQ: reg_rdata_o = irr_q[rd_word*WORD_W +: WORD_W];
      SEL_SVC: reg_rdata_o = isr_q[rd_word*WORD_W +: WORD_W];
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_arb_chk.sv
`timescale 1ns/1ps
module irq_prio_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int STK_DEPTH = 16,
  parameter int PTR_W     = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             accept,
  input logic             eoi_i,
  input logic             pend_valid_o,
  input logic [VEC_W-1:0] pend_vec_o,
  input logic [VEC_W-1:0] stk_top,
  input logic [PTR_W-1:0] stk_ptr,
  input logic             isr_hit,
  input logic [VEC_W-1:0] isr_hi,
  input logic [VEC_W-1:0] ppr,
  input logic             eoi_err_o
);
  assert_rsvd_never_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> pend_vec_o >= VEC_W'(RSVD_VEC));

  assert_push_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> pend_vec_o[VEC_W-1 -: CLS_W] > stk_top[VEC_W-1 -: CLS_W]);

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> stk_ptr < PTR_W'(STK_DEPTH));

  assert_accept_retires_pending_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !(pend_valid_o && pend_vec_o == $past(pend_vec_o)));

  assert_ppr_after_push_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> ppr == {$past(pend_vec_o[VEC_W-1 -: CLS_W]), {(VEC_W-CLS_W){1'b0}}});

  assert_eoi_matches_top_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && stk_ptr != '0) |-> (isr_hit && isr_hi == stk_top));

  assert_empty_eoi_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && stk_ptr == '0) |=> eoi_err_o);

  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_err_o |=> eoi_err_o);
endmodule

bind irq_prio_arb irq_prio_arb_chk #(.STK_DEPTH(STK_DEPTH), .PTR_W(PTR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .accept      (accept),
  .eoi_i       (eoi_i),
  .pend_valid_o(pend_valid_o),
  .pend_vec_o  (pend_vec_o),
  .stk_top     (stk_top),
  .stk_ptr     (stk_ptr),
  .isr_hit     (isr_hit),
  .isr_hi      (isr_hi),
  .ppr         (ppr),
  .eoi_err_o   (eoi_err_o)
);

// File: tb/test_irq_prio_arb.sv
`timescale 1ns/1ps
module test_irq_prio_arb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [7:0]  req_vec_i = '0;
  logic        pend_valid_o;
  logic [7:0]  pend_vec_o;
  logic        ack_i = 1'b0;
  logic        eoi_i = 1'b0;
  logic        eoi_err_o;
  logic        reg_we_i = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  irq_prio_arb i_irq_prio_arb (
    .clk_i, .rst_ni, .req_valid_i, .req_vec_i, .pend_valid_o, .pend_vec_o,
    .ack_i, .eoi_i, .eoi_err_o, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o
  );

  // reference state built from the requirements
  logic [255:0] m_irr, m_isr;
  logic [7:0]   m_tpr;
  logic [7:0]   m_stk [0:16];
  int           m_ptr;
  bit           m_err;

  function automatic logic [7:0] m_top();
    return (m_ptr == 0) ? 8'h00 : m_stk[m_ptr];
  endfunction

  function automatic logic [7:0] m_ppr();
    logic [7:0] t;
    t = m_top();
    return (m_tpr[7:4] >= t[7:4]) ? m_tpr : {t[7:4], 4'h0};
  endfunction

  function automatic int m_hi(input logic [255:0] b);
    for (int v = 255; v >= 32; v--) if (b[v]) return v;
    return -1;
  endfunction

  function automatic bit m_pend();
    int h;
    logic [7:0] p;
    h = m_hi(m_irr);
    p = m_ppr();
    return (h >= 0) && (h[7:4] > p[7:4]);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic cmp_all(input string req);
    int h;
    logic [31:0] d;
    h = m_hi(m_irr);
    chk(req, "pend_valid", {31'b0, pend_valid_o}, {31'b0, m_pend()});
    chk(req, "pend_vec", {24'b0, pend_vec_o}, m_pend() ? 32'(h[7:0]) : 32'h0);
    chk(req, "eoi_err", {31'b0, eoi_err_o}, {31'b0, m_err});
    rd(5'd0, d); chk(req, "tpr", d, {24'b0, m_tpr});
    rd(5'd1, d); chk(req, "ppr", d, {24'b0, m_ppr()});
    for (int w = 0; w < 8; w++) begin
      rd(5'(8 + w), d);  chk(req, $sformatf("irr word %0d", w), d, m_irr[w*32 +: 32]);
      rd(5'(16 + w), d); chk(req, $sformatf("isr word %0d", w), d, m_isr[w*32 +: 32]);
    end
  endtask

  // one clock of stimulus; called at a falling edge, returns at the next one
  task automatic op(input bit rq, input logic [7:0] rv, input bit ak, input bit eo,
                    input bit we, input logic [4:0] wa, input logic [31:0] wd);
    int h, s;
    bit acc;
    h   = m_hi(m_irr);
    acc = ak && m_pend() && !eo;
    req_valid_i = rq; req_vec_i = rv; ack_i = ak; eoi_i = eo;
    reg_we_i = we; reg_addr_i = wa; reg_wdata_i = wd;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0; ack_i = 1'b0; eoi_i = 1'b0; reg_we_i = 1'b0;
    if (acc) begin
      m_irr[h] = 1'b0;
      m_isr[h] = 1'b1;
      m_ptr++;
      m_stk[m_ptr] = h[7:0];
    end
    if (rq) m_irr[rv] = 1'b1;
    if (eo) begin
      if (m_ptr == 0) m_err = 1'b1;
      else begin
        s = m_hi(m_isr);
        if (s >= 0) m_isr[s] = 1'b0;
        m_ptr--;
      end
    end
    if (we && wa == 5'd0) m_tpr = wd[7:0];
  endtask

  task automatic req(input logic [7:0] v); op(1, v, 0, 0, 0, 0, 0); endtask
  task automatic ack(); op(0, 0, 1, 0, 0, 0, 0); endtask
  task automatic eoi(); op(0, 0, 0, 1, 0, 0, 0); endtask
  task automatic wr(input logic [4:0] a, input logic [31:0] d); op(0, 0, 0, 0, 1, a, d); endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    m_irr = '0; m_isr = '0; m_tpr = '0; m_ptr = 0; m_err = 0;
    for (int i = 0; i <= 16; i++) m_stk[i] = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk_i);
    do_reset();

    // R1: reset state, every address
    cmp_all("R1");
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d);
      chk("R1", $sformatf("addr %0d", a), d, 32'h0);
    end

    // R2/R3/R5/R6: every vector requested, taken and retired in turn
    for (int v = 0; v < 256; v++) begin
      req(8'(v));
      cmp_all(v < 32 ? "R3" : "R2");
      if (v >= 32) begin
        ack();
        cmp_all("R5");
        eoi();
        cmp_all("R6");
      end
    end

    // R8: task priority sweep, nothing in service
    do_reset();
    req(8'h80);
    for (int t = 0; t < 256; t++) begin
      wr(5'd0, {24'h5a5a5a, 8'(t)});
      cmp_all("R8");
    end

    // R8: writes to other addresses are ignored
    wr(5'd1, 32'hffff_ffff); cmp_all("R8");
    wr(5'd9, 32'hffff_ffff); cmp_all("R8");
    wr(5'd17, 32'hffff_ffff); cmp_all("R8");
    wr(5'd31, 32'hffff_ffff); cmp_all("R8");

    // R7: task priority sweep with 0x80 in service and 0xc3 waiting
    do_reset();
    req(8'h80); ack(); req(8'hc3);
    for (int t = 0; t < 256; t++) begin
      wr(5'd0, 32'(t));
      cmp_all("R7");
    end

    // R5/R6: deepest nesting, one vector per class, then unwind
    do_reset();
    for (int c = 2; c < 16; c++) begin
      req({4'(c), 4'(c) ^ 4'h5});
      ack();
      cmp_all("R5");
    end
    req(8'hf0);
    cmp_all("R4");
    for (int c = 2; c < 16; c++) begin
      eoi();
      cmp_all("R6");
    end

    // R10: end-of-interrupt with nothing in service
    eoi(); cmp_all("R10");
    eoi(); cmp_all("R10");
    req(8'h33); cmp_all("R10");

    // R4: strictly greater class needed
    do_reset();
    req(8'h41); ack(); cmp_all("R4");
    req(8'h47); cmp_all("R4");
    req(8'h62); cmp_all("R4");
    ack();      cmp_all("R4");
    req(8'h50); cmp_all("R4");
    eoi();      cmp_all("R4");

    // R9: request and accept of the same vector together
    do_reset();
    req(8'h70);
    op(1, 8'h70, 1, 0, 0, 0, 0);
    cmp_all("R9");
    eoi();
    cmp_all("R9");

    // R11: ack without a pending vector, and ack beside an end-of-interrupt
    do_reset();
    ack(); cmp_all("R11");
    wr(5'd0, 32'h0000_00a0);
    req(8'h90); ack(); cmp_all("R11");
    wr(5'd0, 32'h0);
    req(8'hb4); ack(); req(8'hd0);
    op(0, 0, 1, 1, 0, 0, 0);
    cmp_all("R11");
    op(0, 0, 1, 1, 0, 0, 0);
    cmp_all("R11");

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule